// File: doc/BRIEF.md
# Bulk Flash Erase-and-Verify Sequencer

This block is a host-side controller that bulk-erases one or more byte-wide flash devices and proves the result byte by byte. A run starts with a preprogram handshake: the sequencer raises a request and waits for an external agent to acknowledge that every byte of every device holds 00h. Only then does it apply the high programming voltage, send the two-write erase command and wait a programmed number of clock cycles for the erase pulse. It then walks the address space. At each byte it sends the erase-verify command with the address, waits the settling time and reads all devices still in play, counting a byte as erased only when it reads FFh.

Several devices share the bus and are selected by a per-device enable vector. After every pulse each device is verified on its own terms. A device that clears every remaining byte is masked and gets no further erase or verify writes. When any device fails at an address, the next pulse is followed by verification that resumes at the lowest failing address. Pulses are counted from 1. The run ends with a pass once every device is masked. It ends with a failure once the cap is reached and some device is still unerased. In both cases the read command goes to all devices, the voltage drops and a one-cycle done pulse reports the pass flag, the pulse count and the per-device erased vector.

States: IDLE (waits for start) → PREPROG (request held until acknowledge) → SETUP (first 20h) → ERASE (second 20h) → EWAIT (erase time) → VCMD (A0h at the current address) → VWAIT (settling time) → VREAD (read and compare). VREAD goes back to VCMD for the next address, back to SETUP for another pulse, or on to RESTORE (00h to all devices) → FINISH (voltage off, done) → IDLE.

Top module: `erase_seq`

## Requirements
- R1: After reset, pre_req, bus_we, bus_rd, vpp_en, done and pass are 0, and pulse_count and dev_erased are all zeros.
- R2: A start pulse raises pre_req on the next cycle. pre_req stays high, with no bus write, until pre_ack is seen.
- R3: After the acknowledge, the block makes two bus writes of 20h in consecutive cycles to every unmasked device with vpp_en high, and the pulse count starts at 1.
- R4: The first erase-verify write (A0h, with the byte address on bus_addr) comes ERASE_CYC+1 cycles after the second 20h write. The read strobe comes VERIFY_CYC+1 cycles after each A0h write.
- R5: A device's byte passes only when its 8-bit lane of bus_rdata (device d at bits 8d+7..8d) reads FFh. Once every device still in the sweep has passed, the address advances by one. A sweep stops early once every device in it has failed.
- R6: When any device fails, another pulse follows (two 20h writes) and the count rises by one. The first A0h write after that pulse carries the lowest address that failed in the previous sweep.
- R7: A device that passes every byte from the sweep's start address to the last address gets its dev_erased bit set. Its bus_ce bit is then low on every later 20h and A0h write.
- R8: If a sweep ends with an unerased device while the count equals MAX_PULSES, no further pulse is issued, pass stays 0 and pulse_count reads MAX_PULSES.
- R9: At the end, one 00h write goes to all devices with vpp_en high. In the next cycle vpp_en is low and done is high for exactly one cycle. pass is 1 only if every dev_erased bit is set, and pulse_count equals the number of pulses issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to begin a run |
| pre_ack | input | 1 | Preprogram agent reports all bytes at 00h |
| bus_rdata | input | NDEV*8 | Read bytes, one 8-bit lane per device |
| pre_req | output | 1 | Preprogram request, held until acknowledged |
| bus_we | output | 1 | One-cycle command write strobe |
| bus_rd | output | 1 | One-cycle read strobe |
| bus_addr | output | AW | Byte address |
| bus_wdata | output | 8 | Command byte |
| bus_ce | output | NDEV | Per-device enable for the current access |
| vpp_en | output | 1 | High-voltage enable |
| done | output | 1 | One-cycle end-of-run pulse |
| pass | output | 1 | Every device erased |
| pulse_count | output | $clog2(MAX_PULSES+1) | Erase pulses issued in the last run |
| dev_erased | output | NDEV | Per-device erased (masked) status |

## Verification
On every cycle the assertions check the following. Read and write strobes never overlap, and pre_req holds without bus writes until the acknowledge. No 20h write enables a device already marked erased. The address holds steady from a verify write into the wait. The count never exceeds its cap. The restore write is followed by a single done cycle with the voltage off, and a pass report comes with a full erased vector. Only the bench scenarios can show the rest, because it depends on the state of the flash model. These are the exact cycle gaps of the erase and settling waits, that verification resumes at the failing address, that early-stopping sweeps issue the right number of verify writes, and that each device receives exactly the number of erase operations its slowest byte needs before it is masked.

// File: rtl/erase_seq_pkg.sv
package erase_seq_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_PREPROG,
        S_SETUP,
        S_ERASE,
        S_EWAIT,
        S_VCMD,
        S_VWAIT,
        S_VREAD,
        S_RESTORE,
        S_FINISH
    } seq_state_t;

    localparam logic [7:0] CMD_READ    = 8'h00;
    localparam logic [7:0] CMD_ERASE   = 8'h20;
    localparam logic [7:0] CMD_EVERIFY = 8'hA0;

endpackage

// File: rtl/erase_seq_timer.sv
// Wait counter shared by the erase and settling waits; counts while run is high.
module erase_seq_timer #(
    parameter int unsigned LONG_CYC  = 16,
    parameter int unsigned SHORT_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic sel_long,
    output logic expired
);
    localparam int unsigned MAXC = (LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC;
    localparam int unsigned TW   = $clog2(MAXC + 1);

    logic [TW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt <= '0;
        else if (run) cnt <= cnt + 1'b1;
        else          cnt <= '0;
    end

    assign expired = run && (cnt == (sel_long ? TW'(LONG_CYC - 1) : TW'(SHORT_CYC - 1)));

endmodule

// File: rtl/erase_seq_verify.sv
// Per-device comparison of a read byte against the all-ones erased value.
module erase_seq_verify #(
    parameter int unsigned NDEV = 2,
    parameter int unsigned DW   = 8
) (
    input  logic [NDEV*DW-1:0] rdata,
    input  logic [NDEV-1:0]    active,
    output logic [NDEV-1:0]    fail
);
    for (genvar g = 0; g < NDEV; g++) begin : g_lane
        assign fail[g] = active[g] && (rdata[g*DW +: DW] != {DW{1'b1}});
    end
endmodule

// File: rtl/erase_seq.sv
module erase_seq
    import erase_seq_pkg::*;
#(
    parameter int unsigned NDEV       = 2,
    parameter int unsigned AW         = 17,
    parameter int unsigned ERASE_CYC  = 1_000_000,
    parameter int unsigned VERIFY_CYC = 600,
    parameter int unsigned MAX_PULSES = 1000,
    localparam int unsigned CW        = $clog2(MAX_PULSES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              pre_ack,
    input  logic [NDEV*8-1:0] bus_rdata,
    output logic              pre_req,
    output logic              bus_we,
    output logic              bus_rd,
    output logic [AW-1:0]     bus_addr,
    output logic [7:0]        bus_wdata,
    output logic [NDEV-1:0]   bus_ce,
    output logic              vpp_en,
    output logic              done,
    output logic              pass,
    output logic [CW-1:0]     pulse_count,
    output logic [NDEV-1:0]   dev_erased
);
    localparam logic [AW-1:0] LAST_ADDR = {AW{1'b1}};

    seq_state_t      state, state_nx;
    logic [AW-1:0]   addr, resume;
    logic [CW-1:0]   count;
    logic [NDEV-1:0] erased, sweep_fail;
    logic            pass_q;

    logic [NDEV-1:0] active, fail_now, fail_all, still, new_erased;
    logic            is_last, sweep_end, all_done, at_cap, tmr_exp;

    assign active     = ~erased & ~sweep_fail;
    assign fail_all   = sweep_fail | fail_now;
    assign still      = ~erased & ~fail_all;
    assign is_last    = (addr == LAST_ADDR);
    assign sweep_end  = is_last || (still == '0);
    assign new_erased = erased | (is_last ? still : '0);
    assign all_done   = &new_erased;
    assign at_cap     = (count == CW'(MAX_PULSES));

    erase_seq_verify #(.NDEV(NDEV), .DW(8)) u_verify (
        .rdata  (bus_rdata),
        .active (active),
        .fail   (fail_now)
    );

    erase_seq_timer #(.LONG_CYC(ERASE_CYC), .SHORT_CYC(VERIFY_CYC)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      ((state == S_EWAIT) || (state == S_VWAIT)),
        .sel_long (state == S_EWAIT),
        .expired  (tmr_exp)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:    if (start)   state_nx = S_PREPROG;
            S_PREPROG: if (pre_ack) state_nx = S_SETUP;
            S_SETUP:   state_nx = S_ERASE;
            S_ERASE:   state_nx = S_EWAIT;
            S_EWAIT:   if (tmr_exp) state_nx = S_VCMD;
            S_VCMD:    state_nx = S_VWAIT;
            S_VWAIT:   if (tmr_exp) state_nx = S_VREAD;
            S_VREAD: begin
                if (!sweep_end)           state_nx = S_VCMD;
                else if (all_done || at_cap) state_nx = S_RESTORE;
                else                      state_nx = S_SETUP;
            end
            S_RESTORE: state_nx = S_FINISH;
            S_FINISH:  state_nx = S_IDLE;
            default:   state_nx = S_IDLE;
        endcase
    end

    // Address, pulse count and per-device mask
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr <= '0; resume <= '0; count <= '0;
            erased <= '0; sweep_fail <= '0; pass_q <= 1'b0;
        end else begin
            unique case (state)
                S_PREPROG: if (pre_ack) begin
                    addr <= '0; resume <= '0; count <= CW'(1);
                    erased <= '0; pass_q <= 1'b0;
                end
                S_EWAIT: if (tmr_exp) begin
                    addr       <= resume;
                    sweep_fail <= '0;
                end
                S_VREAD: begin
                    sweep_fail <= fail_all;
                    if ((fail_now != '0) && (sweep_fail == '0)) resume <= addr;
                    if (!sweep_end) addr <= addr + 1'b1;
                    else begin
                        erased <= new_erased;
                        if (all_done)     pass_q <= 1'b1;
                        else if (!at_cap) count  <= count + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        pre_req   = (state == S_PREPROG);
        bus_we    = 1'b0;
        bus_rd    = 1'b0;
        bus_wdata = CMD_READ;
        bus_ce    = '0;
        vpp_en    = 1'b0;
        done      = 1'b0;
        unique case (state)
            S_SETUP, S_ERASE: begin
                bus_we = 1'b1; bus_wdata = CMD_ERASE; bus_ce = ~erased; vpp_en = 1'b1;
            end
            S_EWAIT, S_VWAIT: vpp_en = 1'b1;
            S_VCMD: begin
                bus_we = 1'b1; bus_wdata = CMD_EVERIFY; bus_ce = active; vpp_en = 1'b1;
            end
            S_VREAD: begin
                bus_rd = 1'b1; bus_ce = active; vpp_en = 1'b1;
            end
            S_RESTORE: begin
                bus_we = 1'b1; bus_wdata = CMD_READ; bus_ce = '1; vpp_en = 1'b1;
            end
            S_FINISH: done = 1'b1;
            default: ;
        endcase
    end

    assign bus_addr    = addr;
    assign pass        = pass_q;
    assign pulse_count = count;
    assign dev_erased  = erased;

endmodule

// File: rtl/erase_seq_checker.sv
module erase_seq_checker #(
    parameter int unsigned NDEV       = 2,
    parameter int unsigned AW         = 17,
    parameter int unsigned MAX_PULSES = 1000,
    localparam int unsigned CW        = $clog2(MAX_PULSES + 1)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            pre_req,
    input logic            pre_ack,
    input logic            bus_we,
    input logic            bus_rd,
    input logic [AW-1:0]   bus_addr,
    input logic [7:0]      bus_wdata,
    input logic [NDEV-1:0] bus_ce,
    input logic            vpp_en,
    input logic            done,
    input logic            pass,
    input logic [CW-1:0]   pulse_count,
    input logic [NDEV-1:0] dev_erased
);
    assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pre_req && !pre_ack |=> pre_req);
    assert_no_write_in_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pre_req |-> !bus_we);
    assert_erase_has_vpp_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we && bus_wdata == 8'h20 |-> vpp_en);
    assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && bus_rd));
    assert_addr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we && bus_wdata == 8'hA0 |=> $stable(bus_addr));
    assert_masked_no_erase_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we && bus_wdata == 8'h20 |-> (bus_ce & dev_erased) == '0);
    assert_count_cap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_count <= CW'(MAX_PULSES));
    assert_restore_then_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we && bus_wdata == 8'h00 |=> done && !vpp_en);
    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_pass_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done && pass |-> &dev_erased);
endmodule

bind erase_seq erase_seq_checker #(.NDEV(NDEV), .AW(AW), .MAX_PULSES(MAX_PULSES)) u_chk (
    .clk(clk), .rst_n(rst_n), .pre_req(pre_req), .pre_ack(pre_ack),
    .bus_we(bus_we), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ce(bus_ce), .vpp_en(vpp_en), .done(done), .pass(pass),
    .pulse_count(pulse_count), .dev_erased(dev_erased)
);

// File: tb/erase_seq_bench.sv
`timescale 1ns/1ps
module erase_seq_bench;
    localparam int NDEV = 2;
    localparam int AW   = 4;
    localparam int NB   = 16;
    localparam int ECYC = 12;
    localparam int VCYC = 4;
    localparam int MAXP = 6;
    localparam int CW   = $clog2(MAXP + 1);

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, pre_ack = 1'b0;
    logic [NDEV*8-1:0] bus_rdata;
    logic pre_req, bus_we, bus_rd, vpp_en, done, pass;
    logic [AW-1:0] bus_addr;
    logic [7:0] bus_wdata;
    logic [NDEV-1:0] bus_ce, dev_erased;
    logic [CW-1:0] pulse_count;

    always #5 clk = ~clk;

    erase_seq #(.NDEV(NDEV), .AW(AW), .ERASE_CYC(ECYC), .VERIFY_CYC(VCYC), .MAX_PULSES(MAXP)) u_erase_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .pre_ack(pre_ack), .bus_rdata(bus_rdata),
        .pre_req(pre_req), .bus_we(bus_we), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_ce(bus_ce), .vpp_en(vpp_en), .done(done), .pass(pass),
        .pulse_count(pulse_count), .dev_erased(dev_erased)
    );

    // Flash model: byte reads FFh once the device has had at least need[] erase operations
    int need [NDEV][NB];
    int devp [NDEV];
    logic [7:0] prev [NDEV];
    int n20 [NDEV];
    int na0d [NDEV];
    int na0, restore_seen, cyc, last20, lasta0, gap_e, gap_r, gap20_bad, vaddr;
    logic [7:0] last_wdata;
    logic after_pulse;
    int checks = 0, fails = 0;
    logic finished = 1'b0;

    always_comb begin
        for (int d = 0; d < NDEV; d++)
            bus_rdata[d*8 +: 8] = (devp[d] >= need[d][bus_addr]) ? 8'hFF : 8'h00;
    end

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (bus_we) begin
            for (int d = 0; d < NDEV; d++) begin
                if (bus_ce[d]) begin
                    if (bus_wdata == 8'h20) begin
                        n20[d] = n20[d] + 1;
                        if (prev[d] == 8'h20) begin devp[d] = devp[d] + 1; prev[d] = 8'hEE; end
                        else prev[d] = 8'h20;
                    end else prev[d] = bus_wdata;
                    if (bus_wdata == 8'hA0) na0d[d] = na0d[d] + 1;
                end
            end
            if (bus_wdata == 8'h20) begin
                if (last_wdata == 8'h20 && (cyc - last20) != 1) gap20_bad = gap20_bad + 1;
                last20 = cyc; after_pulse = 1'b1;
            end
            if (bus_wdata == 8'hA0) begin
                na0 = na0 + 1; lasta0 = cyc;
                if (after_pulse) begin gap_e = cyc - last20; vaddr = int'(bus_addr); after_pulse = 1'b0; end
            end
            if (bus_wdata == 8'h00 && bus_ce == '1 && vpp_en) restore_seen = restore_seen + 1;
            last_wdata = bus_wdata;
        end
        if (bus_rd) gap_r = cyc - lasta0;
    end

    task automatic chk(input string req, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic clear_model();
        for (int d = 0; d < NDEV; d++) begin
            devp[d] = 0; prev[d] = 8'h00; n20[d] = 0; na0d[d] = 0;
            for (int a = 0; a < NB; a++) need[d][a] = 1;
        end
        na0 = 0; restore_seen = 0; gap_e = -1; gap_r = -1; gap20_bad = 0; vaddr = -1;
        last_wdata = 8'h00; after_pulse = 1'b0; last20 = 0; lasta0 = 0;
    endtask

    // Run one erase sequence; ack_delay cycles before the preprogram acknowledge
    task automatic run_seq(input int ack_delay, output int got_pass);
        int t;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk("R2", int'(pre_req), 1, "pre_req after start");
        for (int i = 0; i < ack_delay; i++) begin
            @(negedge clk);
            if (!pre_req || bus_we) chk("R2", int'(pre_req && !bus_we), 1, "request held without writes");
        end
        pre_ack = 1'b1;
        @(negedge clk) pre_ack = 1'b0;
        t = 0;
        while (!done && t < 20000) begin @(negedge clk); t++; end
        chk("R9", int'(t < 20000), 1, "done reached");
        chk("R9", int'(vpp_en), 0, "vpp_en low with done");
        chk("R9", restore_seen, 1, "one 00h restore write to all devices");
        got_pass = int'(pass);
        @(negedge clk);
        chk("R9", int'(done), 0, "done lasts one cycle");
    endtask

    task automatic t_reset();
        chk("R1", int'(pre_req), 0, "pre_req");
        chk("R1", int'(bus_we) + int'(bus_rd), 0, "strobes");
        chk("R1", int'(vpp_en) + int'(done) + int'(pass), 0, "vpp/done/pass");
        chk("R1", int'(pulse_count), 0, "pulse_count");
        chk("R1", int'(dev_erased), 0, "dev_erased");
    endtask

    task automatic t_clean();
        int p;
        clear_model();
        run_seq(5, p);
        chk("R3", n20[0] + n20[1], 4, "two 20h writes per device");
        chk("R3", gap20_bad, 0, "20h writes back to back");
        chk("R4", gap_e, ECYC + 1, "erase wait gap");
        chk("R4", gap_r, VCYC + 1, "settling gap");
        chk("R5", na0, NB, "one verify per address");
        chk("R9", p, 1, "pass");
        chk("R9", int'(pulse_count), 1, "pulse_count");
        chk("R9", int'(dev_erased), 3, "dev_erased");
    endtask

    task automatic t_mid_fail();
        int p;
        clear_model();
        need[0][5] = 3;
        run_seq(1, p);
        chk("R6", int'(pulse_count), 3, "pulses");
        chk("R6", vaddr, 5, "resume address");
        chk("R6", na0, 28, "verify writes total");
        chk("R6", devp[0], 3, "dev0 erase ops");
        chk("R7", devp[1], 1, "masked dev1 erase ops");
        chk("R7", na0d[1], NB, "masked dev1 verify writes");
        chk("R7", na0d[0], 18, "dev0 verify writes");
        chk("R9", p, 1, "pass");
        chk("R9", int'(dev_erased), 3, "dev_erased");
    endtask

    task automatic t_early_stop();
        int p;
        clear_model();
        need[1][0] = 2;
        need[0][3] = 2;
        run_seq(0, p);
        chk("R5", na0, 4 + NB, "early stop then full sweep");
        chk("R6", vaddr, 0, "resume at lowest failing address");
        chk("R6", int'(pulse_count), 2, "pulses");
        chk("R9", p, 1, "pass");
    endtask

    task automatic t_last_addr();
        int p;
        clear_model();
        need[0][NB-1] = 2;
        run_seq(2, p);
        chk("R6", vaddr, NB - 1, "resume at last address");
        chk("R6", na0, NB + 1, "verify writes");
        chk("R7", devp[1], 1, "dev1 masked after first pulse");
        chk("R9", int'(pulse_count), 2, "pulses");
    endtask

    task automatic t_cap();
        int p;
        clear_model();
        need[1][0] = 100;
        run_seq(3, p);
        chk("R8", p, 0, "pass at cap");
        chk("R8", int'(pulse_count), MAXP, "pulse_count at cap");
        chk("R8", devp[1], MAXP, "dev1 erase ops");
        chk("R8", int'(dev_erased), 1, "dev_erased");
        chk("R7", devp[0], 1, "dev0 masked");
    endtask

    initial begin
        clear_model();
        cyc = 0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_clean();
        t_mid_fail();
        t_early_stop();
        t_last_addr();
        t_cap();
        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule